// File: doc/BRIEF.md
# FSK Carrier Qualifier and Bit Recovery

This block sits behind the analog front end of a 1200/2200 Hz frequency-shift-keyed receiver. It takes two asynchronous comparator outputs. One is a zero-crossing comparator that follows the filtered line signal. The other is an amplitude comparator that pulses once per carrier cycle while the signal is above the detection threshold. The block runs on a 460.8 kHz timebase. It decides whether a usable carrier is present and recovers the received bit by measuring the time between rising edges of the zero-crossing stream. It then presents three outputs: a carrier flag, a primary data output that is masked by the carrier flag, and an alternative data output that idles high when no carrier is present.

Carrier qualification runs as a three-state machine:
- `CD_IDLE`: no run is in progress.
- `CD_ARM`: counting a run of consecutive pulses.
- `CD_LOCK`: carrier asserted.

The transitions are:
- `CD_IDLE -> CD_ARM` on the first pulse.
- `CD_ARM -> CD_LOCK` on the pulse that completes the run.
- `CD_ARM -> CD_IDLE` and `CD_LOCK -> CD_IDLE` when the gap expires, that is when no pulse arrives for `GAP_LIMIT` cycles.
- Any state to `CD_IDLE` while the transmit-active input is high.

Bit recovery keeps a two-state register, `BIT_MARK` or `BIT_SPACE`. It is reloaded on every rising edge of the data comparator.

The configuration input `idle_high_i` selects what the primary output shows when there is no carrier: low, or the alternative output's behaviour.

Top module: `fsk_rx_qualifier`

## Requirements
- R1: The carrier output rises only on the fourth pulse (`RUN_LEN`) of an unbroken run from the carrier comparator. Three pulses leave it low.
- R2: Once asserted, the carrier output stays high as long as each next carrier pulse comes within `GAP_LIMIT` (1152) clock cycles of the previous one, which is 2.5 ms at 460.8 kHz.
- R3: When `GAP_LIMIT` cycles pass with no carrier pulse, the carrier output drops and the run count clears. Asserting it again takes four fresh consecutive pulses.
- R4: While `tx_active_i` is high, the carrier output is low and carrier pulses are ignored. After release, a new run of four pulses is needed.
- R5: The recovered bit is 1 (mark) when the period between successive data-comparator rising edges is at least `MARK_MIN` (297) cycles. It is 0 (space) when the period is shorter. A 384-cycle period (1200 Hz) gives 1 and a 209-cycle period (2200 Hz) gives 0.
- R6: With `idle_high_i` = 0, `rx_data_o` is low whenever the carrier output is low, and equals the recovered bit when the carrier output is high.
- R7: `rx_data_alt_o` equals (NOT carrier) OR recovered bit, so it is high with no carrier.
- R8: With `idle_high_i` = 1, `rx_data_o` follows `rx_data_alt_o`. It is high with no carrier and equals the recovered bit with a carrier.
- R9: After reset the carrier output is 0 and the recovered bit is mark, so `rx_data_o` = 0 and `rx_data_alt_o` = 1 (with `idle_high_i` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 460.8 kHz timebase |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_cmp_i | input | 1 | Zero-crossing comparator output, asynchronous |
| carr_cmp_i | input | 1 | Carrier amplitude comparator output, asynchronous |
| tx_active_i | input | 1 | High while the modem transmits; blocks carrier detection |
| idle_high_i | input | 1 | 1: primary data output idles high without a carrier |
| carrier_o | output | 1 | Carrier present |
| rx_data_o | output | 1 | Qualified received data |
| rx_data_alt_o | output | 1 | (NOT carrier) OR received data |

## Verification
A run counter stuck one step off would show at the ports as a carrier flag that rises on the third or fifth pulse. The fault becomes visible within one carrier period of the point where the flag should have risen. A gap timer with the wrong limit would hold or drop the flag at the wrong time. Probing with gaps just under and just over the limit exposes it within about 100 cycles of the expected edge. A recovered-bit register that fails to reload would leave both data outputs at the old level for a whole tone burst while the carrier flag is high. A state machine left in lock during transmit would show a carrier flag in the first cycle after `tx_active_i` goes high.

// File: rtl/fsk_rx_qual_pkg.sv
package fsk_rx_qual_pkg;

    typedef enum logic [1:0] {
        CD_IDLE = 2'd0,
        CD_ARM  = 2'd1,
        CD_LOCK = 2'd2
    } cd_state_e;

    typedef enum logic {
        BIT_SPACE = 1'b0,
        BIT_MARK  = 1'b1
    } bit_state_e;

endpackage

// File: rtl/fsk_sync_edge.sv
module fsk_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] chain_q;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // chain_q[STAGES-1] is the synchronised level; the last stage is its delayed copy
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/fsk_carrier_fsm.sv
module fsk_carrier_fsm
    import fsk_rx_qual_pkg::*;
#(
    parameter int GAP_LIMIT = 1152,
    parameter int RUN_LEN   = 4,
    localparam int GAP_W    = $clog2(GAP_LIMIT + 1),
    localparam int RUN_W    = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic             tx_active_i,
    output logic             carrier_o,
    output logic [GAP_W-1:0] gap_cnt_o,
    output logic [RUN_W-1:0] run_cnt_o
);
    cd_state_e        state_q, state_d;
    logic [GAP_W-1:0] gap_q;
    logic [RUN_W-1:0] run_q;
    logic             expire;

    // gap expires on the cycle the timer would reach its limit with no pulse
    assign expire = !pulse_i && (gap_q == GAP_W'(GAP_LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CD_IDLE: if (pulse_i) state_d = CD_ARM;
            CD_ARM: begin
                if (expire)
                    state_d = CD_IDLE;
                else if (pulse_i && run_q == RUN_W'(RUN_LEN - 1))
                    state_d = CD_LOCK;
            end
            CD_LOCK: if (expire) state_d = CD_IDLE;
            default: state_d = CD_IDLE;
        endcase
        if (tx_active_i) state_d = CD_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= GAP_W'(GAP_LIMIT);
        end else if (pulse_i) begin
            gap_q <= '0;
        end else if (gap_q != GAP_W'(GAP_LIMIT)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (state_d == CD_IDLE) begin
            run_q <= '0;
        end else if (pulse_i && run_q != RUN_W'(RUN_LEN)) begin
            run_q <= run_q + 1'b1;
        end
    end

    always_comb begin
        carrier_o = (state_q == CD_LOCK) && !tx_active_i;
        gap_cnt_o = gap_q;
        run_cnt_o = run_q;
    end
endmodule

// File: rtl/fsk_period_classifier.sv
module fsk_period_classifier
    import fsk_rx_qual_pkg::*;
#(
    parameter int MARK_MIN = 297,
    localparam int PER_SAT = 2 * MARK_MIN,
    localparam int PER_W   = $clog2(PER_SAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic bit_o
);
    bit_state_e       bit_q;
    logic [PER_W-1:0] per_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= PER_W'(PER_SAT);
            bit_q <= BIT_MARK;
        end else if (edge_i) begin
            per_q <= '0;
            // counter holds period-1 at the edge
            bit_q <= (per_q >= PER_W'(MARK_MIN - 1)) ? BIT_MARK : BIT_SPACE;
        end else if (per_q != PER_W'(PER_SAT)) begin
            per_q <= per_q + 1'b1;
        end
    end

    assign bit_o = (bit_q == BIT_MARK);
endmodule

// File: rtl/fsk_rx_qualifier.sv
module fsk_rx_qualifier #(
    parameter int GAP_LIMIT   = 1152,
    parameter int RUN_LEN     = 4,
    parameter int MARK_MIN    = 297,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_cmp_i,
    input  logic carr_cmp_i,
    input  logic tx_active_i,
    input  logic idle_high_i,
    output logic carrier_o,
    output logic rx_data_o,
    output logic rx_data_alt_o
);
    localparam int GAP_W = $clog2(GAP_LIMIT + 1);
    localparam int RUN_W = $clog2(RUN_LEN + 1);

    logic [1:0]       raw_in;
    logic [1:0]       rises;
    logic             car_pulse;
    logic             dat_pulse;
    logic             rx_bit;
    logic [GAP_W-1:0] gap_cnt;
    logic [RUN_W-1:0] run_cnt;

    assign raw_in = {carr_cmp_i, data_cmp_i};

    genvar i;
    generate
        for (i = 0; i < 2; i++) begin : g_sync
            fsk_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .async_i(raw_in[i]),
                .rise_o (rises[i])
            );
        end
    endgenerate

    assign dat_pulse = rises[0];
    assign car_pulse = rises[1];

    fsk_carrier_fsm #(.GAP_LIMIT(GAP_LIMIT), .RUN_LEN(RUN_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_i    (car_pulse),
        .tx_active_i(tx_active_i),
        .carrier_o  (carrier_o),
        .gap_cnt_o  (gap_cnt),
        .run_cnt_o  (run_cnt)
    );

    fsk_period_classifier #(.MARK_MIN(MARK_MIN)) u_cls (
        .clk   (clk),
        .rst_n (rst_n),
        .edge_i(dat_pulse),
        .bit_o (rx_bit)
    );

    always_comb begin
        rx_data_alt_o = ~carrier_o | rx_bit;
        rx_data_o     = idle_high_i ? rx_data_alt_o : (carrier_o & rx_bit);
    end
endmodule

// File: rtl/fsk_rx_qualifier_chk.sv
module fsk_rx_qualifier_chk #(
    parameter int GAP_LIMIT = 1152,
    parameter int RUN_LEN   = 4,
    localparam int GAP_W    = $clog2(GAP_LIMIT + 1),
    localparam int RUN_W    = $clog2(RUN_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_active,
    input logic             idle_high,
    input logic             carrier,
    input logic             rx_data,
    input logic             rx_alt,
    input logic             car_pulse,
    input logic [RUN_W-1:0] run_cnt,
    input logic [GAP_W-1:0] gap_cnt
);
    p_four_pulses_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier) |-> $past(run_cnt) == RUN_W'(RUN_LEN - 1));

    p_rise_on_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier) |-> $past(car_pulse));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        carrier && gap_cnt < GAP_W'(GAP_LIMIT - 1) |=> carrier || tx_active);

    p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        carrier && !car_pulse && gap_cnt == GAP_W'(GAP_LIMIT - 1) |=> !carrier);

    p_tx_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> !carrier);

    p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_high && !carrier |-> !rx_data);

    p_alt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier |-> rx_alt);

    p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_high && !carrier |-> rx_data);
endmodule

bind fsk_rx_qualifier fsk_rx_qualifier_chk #(
    .GAP_LIMIT(GAP_LIMIT),
    .RUN_LEN  (RUN_LEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_active(tx_active_i),
    .idle_high(idle_high_i),
    .carrier  (carrier_o),
    .rx_data  (rx_data_o),
    .rx_alt   (rx_data_alt_o),
    .car_pulse(car_pulse),
    .run_cnt  (run_cnt),
    .gap_cnt  (gap_cnt)
);

// File: tb/fsk_rx_qualifier_test.sv
`timescale 1ns/1ps
module fsk_rx_qualifier_test;
    localparam int MARK_P  = 384;
    localparam int SPACE_P = 209;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data_cmp = 1'b0, carr_cmp = 1'b0, tx_active = 1'b0, idle_high = 1'b0;
    logic carrier, rx_data, rx_alt;
    int   errors = 0, checks = 0;
    bit   done = 1'b0;

    typedef struct {
        logic  cd;
        logic  rxd;
        logic  alt;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    fsk_rx_qualifier uut (
        .clk(clk), .rst_n(rst_n), .data_cmp_i(data_cmp), .carr_cmp_i(carr_cmp),
        .tx_active_i(tx_active), .idle_high_i(idle_high),
        .carrier_o(carrier), .rx_data_o(rx_data), .rx_data_alt_o(rx_alt)
    );

    // monitor: compares queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (carrier !== e.cd || rx_data !== e.rxd || rx_alt !== e.alt) begin
                    errors++;
                    $display("FAIL %s: cd/rxd/alt actual %b%b%b expected %b%b%b",
                             e.tag, carrier, rx_data, rx_alt, e.cd, e.rxd, e.alt);
                end
            end
        end
    end

    task automatic expect_out(input logic cd, input logic rxd, input logic alt,
                              input string tag);
        exp_t e;
        e.cd = cd; e.rxd = rxd; e.alt = alt; e.tag = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    task automatic tone(input int period, input int n);
        for (int k = 0; k < n; k++) begin
            data_cmp = 1'b1;
            carr_cmp = 1'b1;
            repeat (4) @(negedge clk);
            carr_cmp = 1'b0;
            repeat (period / 2 - 4) @(negedge clk);
            data_cmp = 1'b0;
            repeat (period - period / 2) @(negedge clk);
        end
    endtask

    task automatic quiet(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(1'b0, 1'b0, 1'b1, "R9 reset state");

        tone(MARK_P, 3);
        expect_out(1'b0, 1'b0, 1'b1, "R1 three pulses keep carrier low");
        tone(MARK_P, 1);
        expect_out(1'b1, 1'b1, 1'b1, "R1 fourth pulse asserts, R5 mark");

        tone(SPACE_P, 8);
        expect_out(1'b1, 1'b0, 1'b0, "R5 space gives 0, R2 held, R6 R7 follow bit");

        quiet(1300);
        expect_out(1'b0, 1'b0, 1'b1, "R3 drop after gap, R6 masked, R7 idles high");
        idle_high = 1'b1;
        quiet(1);
        expect_out(1'b0, 1'b1, 1'b1, "R8 idle-high option without carrier");
        idle_high = 1'b0;

        tone(MARK_P, 3);
        expect_out(1'b0, 1'b0, 1'b1, "R3 three fresh pulses do not re-assert");
        tone(MARK_P, 1);
        expect_out(1'b1, 1'b1, 1'b1, "R3 fourth fresh pulse re-asserts");

        quiet(700);
        expect_out(1'b1, 1'b1, 1'b1, "R2 gap just under limit holds");
        tone(MARK_P, 1);
        quiet(850);
        expect_out(1'b0, 1'b0, 1'b1, "R3 gap just over limit drops");

        tone(MARK_P, 4);
        expect_out(1'b1, 1'b1, 1'b1, "R1 relock before transmit test");
        tx_active = 1'b1;
        quiet(1);
        expect_out(1'b0, 1'b0, 1'b1, "R4 transmit forces carrier low");
        tone(MARK_P, 5);
        expect_out(1'b0, 1'b0, 1'b1, "R4 pulses ignored while transmitting");
        tx_active = 1'b0;
        tone(MARK_P, 3);
        expect_out(1'b0, 1'b0, 1'b1, "R4 run restarts after transmit");
        tone(MARK_P, 1);
        expect_out(1'b1, 1'b1, 1'b1, "R4 fourth pulse after transmit asserts");

        idle_high = 1'b1;
        quiet(1);
        expect_out(1'b1, 1'b1, 1'b1, "R8 mark with carrier");
        tone(SPACE_P, 4);
        expect_out(1'b1, 1'b0, 1'b0, "R8 space with carrier");
        quiet(1300);
        expect_out(1'b0, 1'b1, 1'b1, "R8 idle high after carrier loss");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule